// File: doc/BRIEF.md
# Dual-Lane Selectable-Ratio Frequency Divider

This block divides a fast input clock by one of three programmed ratios: 4, 100 or 400. For example, a 20 MHz input gives 5 MHz, 200 kHz or 50 kHz. The input clock rate is given by an enable that is high on each input clock period to be counted. Each ratio is built from a fixed chain of three prescaler stages: a mod-4 stage, a second mod-4 stage and a mod-25 stage. A selector routes the carries between them:
- Ratio 4 uses only the first stage.
- Ratio 100 feeds the first stage straight into the mod-25 stage and skips the middle stage.
- Ratio 400 chains all three stages.

There are two identical lanes, a reference lane and a variable lane, and one ratio setting drives both of them. Each lane produces a divided pulse one cycle wide and a phase output. The phase output toggles in the same cycle as every divided pulse, so its timing against the pulse never changes. While the DC-FM mode input is high, the reference lane receives no input clock periods and holds its state. The variable lane keeps counting. A ratio change first clears every stage counter, so no short output period can occur.

Top module: `freq_ratio_divider`

## Requirements
- R1: While the synchronous reset `rst` is high, and in the first cycle after it falls, all four outputs are 0 and every stage counter is cleared.
- R2: With `ratioSel` = 2'b00, each lane pulses once every 4 counted input periods.
- R3: With `ratioSel` = 2'b01, each lane pulses once every 100 counted input periods, and the middle mod-4 stage stays at zero.
- R4: With `ratioSel` = 2'b10, each lane pulses once every 400 counted input periods, using all three stages.
- R5: Code 2'b11 behaves exactly as ratio 4. Switching between 2'b00 and 2'b11 does not clear the counters.
- R6: A divided pulse is high for exactly one clock cycle. It is registered: it is high in the cycle after the edge that counts the final input period of the ratio.
- R7: Input periods are counted only on edges where `inEn` is high. Cycles with `inEn` low stretch the output period.
- R8: While `dcfmMode` is high, the reference lane counts nothing and produces no pulse. When `dcfmMode` falls, the lane resumes from its held count. The variable lane is unaffected.
- R9: When the decoded ratio differs from the active ratio, that cycle clears all counters, pulses and phases and does not count an input period. The first pulse at the new ratio follows the N-th counted period after that cycle.
- R10: Each lane's phase output toggles only in cycles where that lane's pulse is high, and it toggles on every such pulse. It resets to 0.
- R11: While `dcfmMode` stays low, the reference and variable outputs are identical cycle by cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock |
| rst | input | 1 | Synchronous reset, active high |
| ratioSel | input | 2 | Ratio code: 00 = 4, 01 = 100, 10 = 400, 11 = 4 |
| inEn | input | 1 | High on each input period to be counted |
| dcfmMode | input | 1 | DC-FM mode; withholds input periods from the reference lane |
| refPulse | output | 1 | Reference lane divided pulse |
| refPhase | output | 1 | Reference lane phase output |
| varPulse | output | 1 | Variable lane divided pulse |
| varPhase | output | 1 | Variable lane phase output |

## Verification
The assertions assume that `rst` is held high for at least one clock edge before checking starts. Until that edge, the active ratio and the counters are unknown. They also assume that all inputs are steady around each rising edge. The stimulus changes inputs only on the falling edge and begins with two reset cycles. It moves `ratioSel` only between runs, so each ratio change is followed by enough counted periods to show its first full-length output period.

// File: rtl/freq_ratio_divider_pkg.sv
package freq_ratio_divider_pkg;

  typedef enum logic [1:0] {
    RATIO_SHORT = 2'd0,
    RATIO_MID   = 2'd1,
    RATIO_LONG  = 2'd2
  } ratio_e;

  localparam int LANES   = 2;
  localparam int LANE_REF = 0;
  localparam int LANE_VAR = 1;

  typedef struct packed {
    logic             clear;
    logic [LANES-1:0] laneTick;
    ratio_e           ratio;
  } div_strobe_t;

  function automatic ratio_e decodeRatio(input logic [1:0] code);
    case (code)
      2'b01:   decodeRatio = RATIO_MID;
      2'b10:   decodeRatio = RATIO_LONG;
      default: decodeRatio = RATIO_SHORT;
    endcase
  endfunction

endpackage

// File: rtl/freq_ratio_divider_stage.sv
module freq_ratio_divider_stage #(
  parameter int MODULUS = 4
) (
  input  logic                       clk,
  input  logic                       clear,
  input  logic                       inc,
  output logic                       carry,
  output logic [$clog2(MODULUS)-1:0] count
);
  localparam int W = $clog2(MODULUS);
  localparam logic [W-1:0] LAST = W'(MODULUS - 1);

  assign carry = inc && (count == LAST);

  always_ff @(posedge clk) begin
    if (clear)      count <= '0;
    else if (carry) count <= '0;
    else if (inc)   count <= count + 1'b1;
  end

  stageRangeR1: assert property (@(posedge clk) disable iff (clear)
    count <= LAST);

endmodule

// File: rtl/freq_ratio_divider_ctrl.sv
module freq_ratio_divider_ctrl
  import freq_ratio_divider_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic [1:0]  ratioSel,
  input  logic        inEn,
  input  logic        dcfmMode,
  output div_strobe_t strobe
);
  ratio_e activeRatio;
  ratio_e requested;
  logic   ratioChange;

  always_comb begin
    requested   = decodeRatio(ratioSel);
    ratioChange = (requested != activeRatio);
  end

  always_comb begin
    strobe.clear              = rst || ratioChange;
    strobe.laneTick[LANE_REF] = inEn && !dcfmMode && !strobe.clear;
    strobe.laneTick[LANE_VAR] = inEn && !strobe.clear;
    strobe.ratio              = activeRatio;
  end

  always_ff @(posedge clk) begin
    if (rst || ratioChange) activeRatio <= requested;
  end

  // R9: the active ratio only moves after a clearing cycle
  assert_ratio_clear_R9: assert property (@(posedge clk) disable iff (rst)
    (strobe.ratio != $past(strobe.ratio)) |-> $past(strobe.clear));

endmodule

// File: rtl/freq_ratio_divider_lane.sv
module freq_ratio_divider_lane
  import freq_ratio_divider_pkg::*;
#(
  parameter int FIRST_MOD  = 4,
  parameter int MIDDLE_MOD = 4,
  parameter int LAST_MOD   = 25
) (
  input  logic   clk,
  input  logic   clear,
  input  logic   tick,
  input  ratio_e ratio,
  output logic   pulse,
  output logic   phase
);
  localparam int MW = $clog2(MIDDLE_MOD);

  logic [$clog2(FIRST_MOD)-1:0] firstCount;
  logic [MW-1:0]                middleCount;
  logic [$clog2(LAST_MOD)-1:0]  lastCount;
  logic firstCarry, middleCarry, lastCarry;
  logic middleInc, lastInc, terminal;

  freq_ratio_divider_stage #(.MODULUS(FIRST_MOD)) firstStage (
    .clk(clk), .clear(clear), .inc(tick),
    .carry(firstCarry), .count(firstCount));

  freq_ratio_divider_stage #(.MODULUS(MIDDLE_MOD)) middleStage (
    .clk(clk), .clear(clear), .inc(middleInc),
    .carry(middleCarry), .count(middleCount));

  freq_ratio_divider_stage #(.MODULUS(LAST_MOD)) lastStage (
    .clk(clk), .clear(clear), .inc(lastInc),
    .carry(lastCarry), .count(lastCount));

  always_comb begin
    middleInc = (ratio == RATIO_LONG) && firstCarry;
    case (ratio)
      RATIO_LONG: lastInc = middleCarry;
      RATIO_MID:  lastInc = firstCarry;
      default:    lastInc = 1'b0;
    endcase
    terminal = (ratio == RATIO_SHORT) ? firstCarry : lastCarry;
  end

  always_ff @(posedge clk) begin
    if (clear) begin
      pulse <= 1'b0;
      phase <= 1'b0;
    end else begin
      pulse <= terminal;
      if (terminal) phase <= ~phase;
    end
  end

  // R6: divided pulse lasts one cycle
  assert_pulse_width_R6: assert property (@(posedge clk) disable iff (clear)
    pulse |=> !pulse);

  // R10: phase moves only together with a pulse
  assert_phase_tracks_R10: assert property (@(posedge clk) disable iff (clear)
    (!$past(clear) && (phase != $past(phase))) |-> pulse);

  // R7: a pulse always follows a counted input period
  assert_pulse_after_tick_R7: assert property (@(posedge clk) disable iff (clear)
    pulse |-> $past(tick));

  // R3: middle stage idle unless the longest ratio is active
  assert_middle_idle_R3: assert property (@(posedge clk) disable iff (clear)
    (ratio != RATIO_LONG) |-> (middleCount == '0));

endmodule

// File: rtl/freq_ratio_divider.sv
module freq_ratio_divider
  import freq_ratio_divider_pkg::*;
#(
  parameter int FIRST_MOD  = 4,
  parameter int MIDDLE_MOD = 4,
  parameter int LAST_MOD   = 25
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] ratioSel,
  input  logic       inEn,
  input  logic       dcfmMode,
  output logic       refPulse,
  output logic       refPhase,
  output logic       varPulse,
  output logic       varPhase
);
  div_strobe_t      strobe;
  logic [LANES-1:0] lanePulse;
  logic [LANES-1:0] lanePhase;

  freq_ratio_divider_ctrl ctrl_i (
    .clk(clk), .rst(rst), .ratioSel(ratioSel), .inEn(inEn),
    .dcfmMode(dcfmMode), .strobe(strobe));

  for (genvar g = 0; g < LANES; g++) begin : gLane
    freq_ratio_divider_lane #(
      .FIRST_MOD(FIRST_MOD), .MIDDLE_MOD(MIDDLE_MOD), .LAST_MOD(LAST_MOD)
    ) lane_i (
      .clk(clk), .clear(strobe.clear), .tick(strobe.laneTick[g]),
      .ratio(strobe.ratio), .pulse(lanePulse[g]), .phase(lanePhase[g]));
  end

  assign refPulse = lanePulse[LANE_REF];
  assign refPhase = lanePhase[LANE_REF];
  assign varPulse = lanePulse[LANE_VAR];
  assign varPhase = lanePhase[LANE_VAR];

  // R8: no reference pulse after a cycle in DC-FM mode
  assert_ref_held_R8: assert property (@(posedge clk) disable iff (rst)
    $past(dcfmMode) |-> !refPulse);

  // R1: outputs idle in the cycle after reset
  assert_reset_idle_R1: assert property (@(posedge clk)
    $past(rst) |-> !(refPulse || varPulse || refPhase || varPhase));

endmodule

// File: tb/freq_ratio_divider_tb_top.sv
module freq_ratio_divider_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic       rst = 1'b1;
  logic [1:0] ratioSel = 2'b00;
  logic       inEn = 1'b0;
  logic       dcfmMode = 1'b0;
  logic       refPulse, refPhase, varPulse, varPhase;

  freq_ratio_divider dut_i (
    .clk(clk), .rst(rst), .ratioSel(ratioSel), .inEn(inEn),
    .dcfmMode(dcfmMode), .refPulse(refPulse), .refPhase(refPhase),
    .varPulse(varPulse), .varPhase(varPhase));

  int checks = 0;
  int errors = 0;
  int modelN = 0;
  int modelCnt [2];
  logic expPulse [2];
  logic expPhase [2];
  int tally [2];

  function automatic int ratioOf(input logic [1:0] code);
    case (code)
      2'b01:   return 100;
      2'b10:   return 400;
      default: return 4;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // one clock: update the model at the edge, compare at the falling edge
  task automatic step(input string req);
    int n;
    @(posedge clk);
    n = ratioOf(ratioSel);
    if (rst || n != modelN) begin
      modelN = n;
      for (int l = 0; l < 2; l++) begin
        modelCnt[l] = 0; expPulse[l] = 1'b0; expPhase[l] = 1'b0;
      end
    end else begin
      for (int l = 0; l < 2; l++) begin
        if (inEn && (l == 1 || !dcfmMode)) begin
          modelCnt[l]++;
          if (modelCnt[l] == modelN) begin
            modelCnt[l] = 0; expPulse[l] = 1'b1; expPhase[l] = ~expPhase[l];
          end else expPulse[l] = 1'b0;
        end else expPulse[l] = 1'b0;
      end
    end
    @(negedge clk);
    check(refPulse == expPulse[0], req, "refPulse", int'(refPulse), int'(expPulse[0]));
    check(varPulse == expPulse[1], req, "varPulse", int'(varPulse), int'(expPulse[1]));
    check(refPhase == expPhase[0], req, "refPhase", int'(refPhase), int'(expPhase[0]));
    check(varPhase == expPhase[1], req, "varPhase", int'(varPhase), int'(expPhase[1]));
    if (refPulse) tally[0]++;
    if (varPulse) tally[1]++;
  endtask

  task automatic run(input int n, input string req);
    for (int i = 0; i < n; i++) step(req);
  endtask

  task automatic clearTally();
    tally[0] = 0; tally[1] = 0;
  endtask

  task automatic testReset();
    rst = 1'b1; ratioSel = 2'b00; inEn = 1'b1; dcfmMode = 1'b0;
    run(2, "R1");
    rst = 1'b0; inEn = 1'b0;
    step("R1");
    check(!(refPulse || varPulse || refPhase || varPhase), "R1", "outputs after reset",
          int'({refPulse, varPulse, refPhase, varPhase}), 0);
  endtask

  task automatic testDiv4();
    clearTally(); ratioSel = 2'b00; inEn = 1'b1;
    run(20, "R2 R6 R10");
    check(tally[1] == 5, "R2", "var pulses in 20 periods", tally[1], 5);
    check(tally[0] == 5, "R2", "ref pulses in 20 periods", tally[0], 5);
  endtask

  task automatic testDiv100();
    clearTally(); ratioSel = 2'b01; inEn = 1'b1;
    for (int i = 0; i < 201; i++) begin
      step("R3");
      check(refPulse == varPulse && refPhase == varPhase, "R11", "lanes differ",
            int'({refPulse, refPhase}), int'({varPulse, varPhase}));
    end
    check(tally[0] == 2, "R3", "ref pulses in 200 periods", tally[0], 2);
  endtask

  task automatic testDiv400();
    clearTally(); ratioSel = 2'b10; inEn = 1'b1;
    run(801, "R4");
    check(tally[1] == 2, "R4", "var pulses in 800 periods", tally[1], 2);
  endtask

  task automatic testUnused();
    clearTally(); ratioSel = 2'b11; inEn = 1'b1;
    run(13, "R5");
    check(tally[0] == 3, "R5", "pulses with code 11", tally[0], 3);
    ratioSel = 2'b00;
    run(4, "R5");
    check(tally[0] == 4, "R5", "no clear between codes 11 and 00", tally[0], 4);
  endtask

  task automatic testGaps();
    clearTally();
    for (int i = 0; i < 40; i++) begin
      inEn = (i % 3 != 0);
      step("R7");
    end
    check(tally[1] == 6, "R7", "pulses over 26 counted periods", tally[1], 6);
  endtask

  task automatic testDcfm();
    clearTally(); inEn = 1'b1; dcfmMode = 1'b1;
    run(10, "R8");
    check(tally[0] == 0, "R8", "ref pulses in DC-FM mode", tally[0], 0);
    check(tally[1] == 3, "R8", "var pulses in DC-FM mode", tally[1], 3);
    dcfmMode = 1'b0; clearTally();
    run(2, "R8");
    check(tally[0] == 1, "R8", "ref resumes from held count", tally[0], 1);
    check(refPulse == 1'b1, "R8", "ref pulse after resume", int'(refPulse), 1);
  endtask

  task automatic testChange();
    ratioSel = 2'b00; inEn = 1'b1;
    run(2, "R9");
    clearTally(); ratioSel = 2'b01;
    run(100, "R9");
    check(tally[1] == 0, "R9", "no pulse before full new period", tally[1], 0);
    step("R9");
    check(tally[1] == 1 && varPulse, "R9", "first pulse at new ratio", tally[1], 1);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    testReset();
    testDiv4();
    testDiv100();
    testDiv400();
    testUnused();
    testGaps();
    testDcfm();
    testChange();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule